// File: doc/BRIEF.md
# 64-bit Integer ALU with Word Operations

This block is a purely combinational integer arithmetic-logic unit for a 64-bit RISC-V style core. A 4-bit operator code chooses one of ten operations on two 64-bit operands, A and B, and the block returns a 64-bit result. The result is valid in the same cycle as the inputs. The block holds no state.

The operations are:
- add and subtract, each in a full-width form and in a 32-bit word form;
- bitwise XOR, OR and AND;
- logical shift left, logical shift right and arithmetic shift right.

A word-form result is taken from bits 31:0 and then sign-extended from bit 31 to all 64 bits. A shift uses only the low six bits of operand B as its amount. An operator code outside the defined set gives a result of zero.

Top module: `alu64_core`

## Requirements
- R1: Operator code 0 (full add) returns (A + B) modulo 2^64. Any carry out of bit 63 is lost.
- R2: Operator code 2 (word add) adds A[31:0] and B[31:0]. It returns that 32-bit sum in bits 31:0, and bits 63:32 are all copies of the sum's bit 31.
- R3: Operator code 1 (full subtract) returns (A - B) modulo 2^64.
- R4: Operator code 3 (word subtract) returns A[31:0] - B[31:0] in bits 31:0, and bits 63:32 are all copies of that difference's bit 31.
- R5: Operator codes 4, 5 and 6 return the bitwise XOR, OR and AND of A and B across all 64 bits.
- R6: Operator code 7 shifts A left by B[5:0] and fills the vacated low bits with zeros.
- R7: Operator code 8 shifts A right by B[5:0] and fills the vacated high bits with zeros.
- R8: Operator code 9 shifts A right by B[5:0] and fills the vacated high bits with copies of A[63].
- R9: For every shift operation, bits 63:6 of B have no effect on the result.
- R10: Operator codes 10 through 15 return a result of zero whatever the operands are.
- R11: The result depends only on the present inputs. It follows a change of the inputs without any clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operator code; the values are listed in the requirements |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B; for shifts only bits 5:0 are used |
| res_o | output | 64 | Result |

## Verification
The bench builds the unit with its default parameters: a 64-bit data path, 32-bit words and a 4-bit operator code. These values make every code from 0 to 15 reachable, including the six unused codes. They also cover all 64 shift amounts, so the boundary shifts by 0 and by 63 are exercised on operands whose bit 63 is set. Word add and subtract are driven with operands whose 32-bit result has bit 31 set and with operands whose result has it clear, so both directions of the sign extension are observed.

// File: rtl/alu64_pkg.sv
package alu64_pkg;

  localparam int ALU_XLEN = 64;
  localparam int ALU_WLEN = 32;
  localparam int ALU_OPW  = 4;

  typedef enum logic [ALU_OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_ADDW = 4'd2,
    OP_SUBW = 4'd3,
    OP_XOR  = 4'd4,
    OP_OR   = 4'd5,
    OP_AND  = 4'd6,
    OP_SLL  = 4'd7,
    OP_SRL  = 4'd8,
    OP_SRA  = 4'd9
  } alu_op_e;

  // Widen a word-sized value to full width by copying its top bit.
  function automatic logic [ALU_XLEN-1:0] word_sext(input logic [ALU_WLEN-1:0] w);
    return {{(ALU_XLEN-ALU_WLEN){w[ALU_WLEN-1]}}, w};
  endfunction

  // Reverse the bit order of a full-width value (used to turn a left shift into a right shift).
  function automatic logic [ALU_XLEN-1:0] bit_flip(input logic [ALU_XLEN-1:0] v);
    logic [ALU_XLEN-1:0] r;
    for (int i = 0; i < ALU_XLEN; i++) r[i] = v[ALU_XLEN-1-i];
    return r;
  endfunction

endpackage

// File: rtl/alu64_addsub.sv
module alu64_addsub
  import alu64_pkg::*;
#(
  parameter int XLEN = ALU_XLEN,
  parameter int WLEN = ALU_WLEN
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            sub_i,
  input  logic            word_i,
  output logic [XLEN-1:0] sum_o
);

  logic [XLEN-1:0] b_eff;
  logic [XLEN-1:0] full_sum;
  logic [WLEN-1:0] word_part;

  // One shared adder. Subtraction is done as A + ~B + 1.
  assign b_eff     = sub_i ? ~b_i : b_i;
  assign full_sum  = a_i + b_eff + {{(XLEN-1){1'b0}}, sub_i};
  // The low word of the full sum equals the word-only sum.
  assign word_part = full_sum[WLEN-1:0];
  assign sum_o     = word_i ? word_sext(word_part) : full_sum;

  always_comb begin
    if (!$isunknown({word_i, sum_o}) && word_i) begin
      // R2 and R4: the upper bits of a word result all follow bit 31.
      a_r2_word_sext: assert (sum_o[XLEN-1:WLEN] == {(XLEN-WLEN){sum_o[WLEN-1]}})
        else $error("word result is not sign-extended");
    end
  end

endmodule

// File: rtl/alu64_logic.sv
module alu64_logic
  import alu64_pkg::*;
#(
  parameter int XLEN = ALU_XLEN
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [1:0]      fn_i,   // 0 xor, 1 or, 2 and
  output logic [XLEN-1:0] res_o
);

  always_comb begin
    unique case (fn_i)
      2'd0:    res_o = a_i ^ b_i;
      2'd1:    res_o = a_i | b_i;
      2'd2:    res_o = a_i & b_i;
      default: res_o = '0;
    endcase
  end

endmodule

// File: rtl/alu64_shift.sv
module alu64_shift
  import alu64_pkg::*;
#(
  parameter int XLEN = ALU_XLEN,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [SHW-1:0]  amt_i,
  input  logic            left_i,
  input  logic            arith_i,
  output logic [XLEN-1:0] res_o
);

  logic [XLEN-1:0] src;
  logic            fill;
  logic [XLEN-1:0] stage [SHW+1];

  // A left shift is a right shift of the bit-reversed operand, reversed back afterwards.
  assign src      = left_i ? bit_flip(a_i) : a_i;
  assign fill     = arith_i & ~left_i & a_i[XLEN-1];
  assign stage[0] = src;

  // Barrel shifter: stage k moves the value right by 2^k when amount bit k is set.
  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stage[k+1] = amt_i[k] ? {{STEP{fill}}, stage[k][XLEN-1:STEP]} : stage[k];
  end

  assign res_o = left_i ? bit_flip(stage[SHW]) : stage[SHW];

  always_comb begin
    if (!$isunknown({left_i, arith_i, amt_i, a_i, res_o})) begin
      if (left_i && amt_i != '0) begin
        a_r6_sll_low_zero: assert (res_o[0] == 1'b0) else $error("left shift left a one in bit 0");
      end
      if (!left_i && !arith_i && amt_i != '0) begin
        a_r7_srl_top_zero: assert (res_o[XLEN-1] == 1'b0) else $error("logical right shift filled a one");
      end
      if (!left_i && arith_i) begin
        a_r8_sra_keeps_sign: assert (res_o[XLEN-1] == a_i[XLEN-1]) else $error("arithmetic shift lost the sign");
      end
    end
  end

endmodule

// File: rtl/alu64_core.sv
module alu64_core
  import alu64_pkg::*;
#(
  parameter int XLEN = ALU_XLEN,
  parameter int WLEN = ALU_WLEN,
  parameter int OPW  = ALU_OPW,
  localparam int SHW = $clog2(XLEN)
) (
  input  logic [OPW-1:0]  op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o
);

  alu_op_e         op;
  logic            is_sub, is_word;
  logic [1:0]      logic_fn;
  logic            sh_left, sh_arith;
  logic [XLEN-1:0] addsub_res, logic_res, shift_res;

  assign op = alu_op_e'(op_i);

  always_comb begin
    is_sub   = (op == OP_SUB)  || (op == OP_SUBW);
    is_word  = (op == OP_ADDW) || (op == OP_SUBW);
    sh_left  = (op == OP_SLL);
    sh_arith = (op == OP_SRA);
    unique case (op)
      OP_OR:   logic_fn = 2'd1;
      OP_AND:  logic_fn = 2'd2;
      default: logic_fn = 2'd0;
    endcase
  end

  alu64_addsub #(.XLEN(XLEN), .WLEN(WLEN)) i_addsub (
    .a_i(opa_i), .b_i(opb_i), .sub_i(is_sub), .word_i(is_word), .sum_o(addsub_res)
  );

  alu64_logic #(.XLEN(XLEN)) i_logic (
    .a_i(opa_i), .b_i(opb_i), .fn_i(logic_fn), .res_o(logic_res)
  );

  // Only the low shift-amount bits of B reach the shifter (R9).
  alu64_shift #(.XLEN(XLEN)) i_shift (
    .a_i(opa_i), .amt_i(opb_i[SHW-1:0]), .left_i(sh_left), .arith_i(sh_arith), .res_o(shift_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB, OP_ADDW, OP_SUBW: res_o = addsub_res;
      OP_XOR, OP_OR, OP_AND:            res_o = logic_res;
      OP_SLL, OP_SRL, OP_SRA:           res_o = shift_res;
      default:                          res_o = '0;
    endcase
  end

  always_comb begin
    if (!$isunknown({op_i, res_o})) begin
      if (op_i > 4'd9) begin
        a_r10_unused_zero: assert (res_o == '0) else $error("unused code gave a nonzero result");
      end
      if (op == OP_AND) begin
        a_r5_and_subset: assert ((res_o & ~opa_i) == '0) else $error("AND result has bits not in A");
      end
      if (op == OP_OR) begin
        a_r5_or_superset: assert ((res_o & opa_i) == opa_i) else $error("OR result lost bits of A");
      end
    end
  end

endmodule

// File: tb/test_alu64_core.sv
module test_alu64_core;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op;
  logic [63:0] a, b;
  logic [63:0] res;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu64_core i_alu64_core (.op_i(op), .opa_i(a), .opb_i(b), .res_o(res));

  // Behavioural reference written with plain language arithmetic.
  function automatic logic [63:0] model(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    longint sx;
    int     w;
    int     sh;
    sx = longint'(x);
    sh = int'(y % 64);
    case (o)
      4'd0: return x + y;
      4'd1: return x - y;
      4'd2: begin w = int'(x[31:0]) + int'(y[31:0]); return 64'(longint'(w)); end
      4'd3: begin w = int'(x[31:0]) - int'(y[31:0]); return 64'(longint'(w)); end
      4'd4: return x ^ y;
      4'd5: return x | y;
      4'd6: return x & y;
      4'd7: return x << sh;
      4'd8: return x >> sh;
      4'd9: return 64'(sx >>> sh);
      default: return 64'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] o);
    case (o)
      4'd0: return "R1";
      4'd1: return "R3";
      4'd2: return "R2";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h actual=%h expected=%h", req, op, a, b, got, exp);
    end
  endtask

  // Drive one vector just after a clock edge and compare before the next one.
  task automatic apply(input logic [3:0] o, input logic [63:0] x, input logic [63:0] y);
    @(posedge clk);
    #1;
    op = o; a = x; b = y;
    #1;
    check(req_of(o), res, model(o, x, y));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [63:0] r_ref;
    op = 4'd0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", res, 64'd0);  // state after reset with idle inputs

    // R1: carry out of bit 63 lost
    apply(4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    // R3: wrap below zero
    apply(4'd1, 64'd0, 64'd1);
    // R2: word sum with bit 31 set, upper operand bits ignored
    apply(4'd2, 64'h1234_5678_7FFF_FFFF, 64'hABCD_0000_0000_0001);
    check("R2", res, 64'hFFFF_FFFF_8000_0000);
    apply(4'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1);
    check("R2", res, 64'd0);
    // R4: word difference with bit 31 set
    apply(4'd3, 64'h0, 64'h1);
    check("R4", res, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4'd3, 64'hFFFF_FFFF_8000_0000, 64'h1);
    check("R4", res, 64'h0000_0000_7FFF_FFFF);
    // R5
    apply(4'd4, 64'hF0F0_F0F0_F0F0_F0F0, 64'hFF00_FF00_FF00_FF00);
    apply(4'd5, 64'hF0F0_F0F0_F0F0_F0F0, 64'h0F0F_0000_0000_0001);
    apply(4'd6, 64'hF0F0_F0F0_F0F0_F0F0, 64'h3333_3333_3333_3333);
    // R6/R7/R8 boundary shifts on a negative operand
    apply(4'd9, 64'h8000_0000_0000_0000, 64'd63);
    check("R8", res, 64'hFFFF_FFFF_FFFF_FFFF);
    apply(4'd9, 64'h8000_0000_0000_0001, 64'd0);
    check("R8", res, 64'h8000_0000_0000_0001);
    apply(4'd8, 64'h8000_0000_0000_0000, 64'd63);
    check("R7", res, 64'd1);
    apply(4'd8, 64'hC000_0000_0000_0000, 64'd0);
    apply(4'd7, 64'hFFFF_FFFF_FFFF_FFFF, 64'd63);
    check("R6", res, 64'h8000_0000_0000_0000);
    apply(4'd7, 64'h8000_0000_0000_0003, 64'd0);

    // R9: upper bits of B must not change any shift
    for (int k = 0; k < 300; k++) begin
      logic [3:0]  so;
      logic [63:0] x, y;
      so = 4'd7 + 4'($urandom_range(0, 2));
      x  = {$urandom, $urandom};
      y  = {$urandom, $urandom};
      apply(so, x, {58'd0, y[5:0]});
      r_ref = res;
      apply(so, x, y);
      check("R9", res, r_ref);
    end

    // R10: every unused code gives zero
    for (int c = 10; c < 16; c++) begin
      apply(4'(c), {$urandom, $urandom}, {$urandom, $urandom});
      check("R10", res, 64'd0);
    end

    // R11: result follows the inputs with no clock edge
    @(negedge clk);
    op = 4'd0; a = 64'd5; b = 64'd7;
    #1 check("R11", res, 64'd12);
    a = 64'd100;
    #1 check("R11", res, 64'd107);

    // Random sweep of every operator code
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] x, y;
      x = {$urandom, $urandom};
      y = {$urandom, $urandom};
      if (k % 7 == 0) x[63] = 1'b1;
      if (k % 5 == 0) x[31] = 1'b1;
      apply(4'(k % 16), x, y);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule